// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers one-cycle event pulses from on-chip sources (encoder and decoder transfer completion, capture events, transfer list errors and similar) into a sticky 32-bit pending register. It drives a single level-sensitive interrupt line to the host. Software reads the pending register and acknowledges bits by writing ones back to it. It can also inject any pending bit by writing a one to a separate set register, which is useful for testing the interrupt path and for deferring work.

A mask register decides which pending bits reach the interrupt line. Its polarity is inverted: a zero in a mask bit enables that source and a one blocks it. After reset every source is blocked. Only a fixed group of bit positions is wired to hardware sources. The remaining positions behave like the others through the registers, but no hardware pulse reaches them.

Top module: `irq_agg`

## Requirements
- R1: While reset is high and after it falls, the pending register reads 0, the mask register reads 0xFFFFFFFF, `irq` is 0 and `rd_data` is 0.
- R2: Register offsets (byte addresses on `addr`): pending at 0x40, set at 0x44, mask at 0x48. A read of the set register or of any other offset returns 0. A write to any other offset changes nothing. `rd_data` is registered: it shows the register selected by `addr` as it stood before the clock edge that samples `addr`.
- R3: A pulse on `evt` at a hardware-wired position sets that pending bit at the same clock edge. The wired positions are 31, 30, 29, 28, 27, 24, 22, 20, 19 and 18 (`evt` mask 0xF95C0000).
- R4: A pulse on `evt` at any other position leaves the pending register unchanged.
- R5: A write to the set register (0x44) sets each pending bit whose data bit is 1. Data bits at 0 leave their pending bits unchanged.
- R6: A write to the pending register (0x40) clears each bit whose data bit is 1. Data bits at 0 leave their pending bits unchanged.
- R7: When a hardware pulse and a clearing write hit the same pending bit at the same edge, the bit stays set.
- R8: `irq` is registered. After each edge it equals the OR over all bits of (pending AND NOT mask), taken from the register values held before that edge. It therefore falls one cycle after the last enabled pending bit is cleared or masked.
- R9: A mask bit at 0 lets its pending bit drive `irq`. A mask bit at 1 keeps it from doing so. The mask is written at 0x48 and read back at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for `addr` |
| evt | input | 32 | Event pulses from hardware sources |
| irq | output | 1 | Level interrupt to the host |

## Verification
Every register write and every event pulse takes effect at the edge that samples it. A read returns the state from before that edge, so written data shows on `rd_data` after the following edge. `irq` follows register changes one edge after they occur. The bench keeps a model that advances once per edge: it computes the expected `rd_data` and `irq` from the model state before that edge, then updates the model. Inputs change on falling edges and outputs are compared on the next falling edge, so every comparison lands in the cycle where the result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_SET  = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h48;
  // Positions wired to hardware event sources.
  localparam logic [DATA_W-1:0] HW_SRC_MAP = 32'hF95C_0000;

  typedef struct packed {
    logic pend;
    logic set;
    logic mask;
  } wr_sel_t;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  output wr_sel_t       sel
);
  always_comb begin
    sel.pend = wr_en && (addr == OFF_PEND);
    sel.set  = wr_en && (addr == OFF_SET);
    sel.mask = wr_en && (addr == OFF_MASK);
  end
endmodule

// File: rtl/irq_agg_pending.sv
module irq_agg_pending #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] SRC_MAP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt,
  input  logic          clr_en,
  input  logic          set_en,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] pend
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic hit;
    if (SRC_MAP[i]) begin : g_wired
      assign hit = evt[i];
    end else begin : g_soft
      assign hit = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= 1'b0;
      end else if (hit || (set_en && data[i])) begin
        pend[i] <= 1'b1;
      end else if (clr_en && data[i]) begin
        pend[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_agg_mask.sv
module irq_agg_mask #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
    end else if (wr) begin
      mask <= data;
    end
  end
endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pend,
  input  logic [DW-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= |(pend & ~mask);
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned   DW      = DATA_W,
  parameter int unsigned   AW      = ADDR_W,
  parameter logic [DW-1:0] SRC_MAP = HW_SRC_MAP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] evt,
  output logic          irq
);
  wr_sel_t       sel;
  logic [DW-1:0] pend_q;
  logic [DW-1:0] mask_q;

  irq_agg_decode #(.AW(AW)) u_dec (
    .addr (addr),
    .wr_en(wr_en),
    .sel  (sel)
  );

  irq_agg_pending #(.DW(DW), .SRC_MAP(SRC_MAP)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .clr_en(sel.pend),
    .set_en(sel.set),
    .data  (wr_data),
    .pend  (pend_q)
  );

  irq_agg_mask #(.DW(DW)) u_mask (
    .clk (clk),
    .rst (rst),
    .wr  (sel.mask),
    .data(wr_data),
    .mask(mask_q)
  );

  irq_agg_line #(.DW(DW)) u_line (
    .clk (clk),
    .rst (rst),
    .pend(pend_q),
    .mask(mask_q),
    .irq (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (addr)
        OFF_PEND: rd_data <= pend_q;
        OFF_MASK: rd_data <= mask_q;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned   DW      = 32,
  parameter int unsigned   AW      = 8,
  parameter logic [DW-1:0] SRC_MAP = 32'hF95C_0000
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] evt,
  input logic [DW-1:0] pend,
  input logic [DW-1:0] mask,
  input logic          irq
);
  // R1: reset leaves nothing pending, everything masked, line low
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pend == '0 && mask == '1 && irq == 1'b0));

  // R3: a wired event sets its pending bit
  a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
    ((evt & SRC_MAP) != '0) |=> ((pend & $past(evt & SRC_MAP)) == $past(evt & SRC_MAP)));

  // R5: set register write sets the selected bits
  a_r5_set_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h44) |=> ((pend & $past(wr_data)) == $past(wr_data)));

  // R6: without a write to the pending register no bit can fall
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 8'h40) |=> ((pend & $past(pend)) == $past(pend)));

  // R7: an event beats a clearing write on the same bit
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h40) |=> ((pend & $past(evt & SRC_MAP)) == $past(evt & SRC_MAP)));

  // R8: line follows enabled pending bits one cycle later
  a_r8_line: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(pend) & ~$past(mask))));
endmodule

bind irq_agg irq_agg_chk #(.DW(DW), .AW(AW), .SRC_MAP(SRC_MAP)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addr   (addr),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .evt    (evt),
  .pend   (pend_q),
  .mask   (mask_q),
  .irq    (irq)
);

// File: tb/irq_agg_bench.sv
module irq_agg_bench;
  localparam logic [31:0] MAP = 32'hF95C_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] evt = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_pend;
  logic [31:0] m_mask;

  always #5 clk = ~clk;

  irq_agg u_irq_agg (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt(evt), .irq(irq)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a, logic [31:0] p, logic [31:0] m);
    if (a == 8'h40) return p;
    if (a == 8'h48) return m;
    return 32'h0;
  endfunction

  function automatic logic [31:0] next_pend(logic [7:0] a, logic we, logic [31:0] d,
                                            logic [31:0] e, logic [31:0] p);
    logic [31:0] n;
    n = p;
    if (we && a == 8'h40) n = n & ~d;
    if (we && a == 8'h44) n = n | d;
    return n | (e & MAP);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock cycle: drive on falling edge, compare on next falling edge.
  task automatic step(logic [7:0] a, logic we, logic [31:0] d, logic [31:0] e, string tag);
    logic [31:0] xr;
    logic        xi;
    addr = a; wr_en = we; wr_data = d; evt = e;
    @(posedge clk);
    xr = exp_read(a, m_pend, m_mask);
    xi = |(m_pend & ~m_mask);
    m_pend = next_pend(a, we, d, e, m_pend);
    if (we && a == 8'h48) m_mask = d;
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, xr);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, xi});
  endtask

  task automatic idle(logic [7:0] a, string tag);
    step(a, 1'b0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pend = '0;
    m_mask = '1;
    rst = 1'b1;
    evt = '1;
    wr_en = 1'b1; addr = 8'h44; wr_data = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd_data in reset", rd_data, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    idle(8'h40, "R1");
    idle(8'h48, "R1");
    idle(8'h40, "R1 pending after reset");
    idle(8'h48, "R1 mask after reset");

    // R3: each wired source sets its bit
    step(8'h40, 1'b0, 0, 32'h0800_0000, "R3");
    idle(8'h40, "R3 bit27 read");
    step(8'h40, 1'b1, '1, 0, "R6 clear all");
    // R4: unassigned event positions ignored
    step(8'h40, 1'b0, 0, ~MAP, "R4");
    idle(8'h40, "R4 unassigned read");
    step(8'h40, 1'b0, 0, '1, "R3 all wired");
    idle(8'h40, "R3 all wired read");
    step(8'h40, 1'b1, '1, 0, "R6 clear all");
    // R5: set register, including unassigned bits; reads back 0
    step(8'h44, 1'b1, 32'h0000_00A5, 0, "R5");
    idle(8'h44, "R2 set reads zero");
    idle(8'h40, "R5 set read");
    // R6: partial clear
    step(8'h40, 1'b1, 32'h0000_0005, 0, "R6");
    idle(8'h40, "R6 partial clear read");
    // R7: event and clear on same bit
    step(8'h40, 1'b1, 32'h0010_00A0, 32'h0010_0000, "R7");
    idle(8'h40, "R7 event wins read");
    // R2: other offsets
    step(8'h4C, 1'b1, '1, 0, "R2 stray write");
    idle(8'h4C, "R2 stray read");
    idle(8'h40, "R2 stray no effect");
    idle(8'h48, "R2 stray mask unchanged");
    // R9 / R8: enable bit 20, irq rises, then masking drops it
    step(8'h48, 1'b1, 32'hFFEF_FFFF, 0, "R9 enable");
    idle(8'h48, "R9 mask read");
    idle(8'h40, "R8 irq high");
    step(8'h48, 1'b1, '1, 0, "R9 mask off");
    idle(8'h40, "R8 irq falls");
    step(8'h48, 1'b1, 32'h0, 0, "R9 all enabled");
    step(8'h40, 1'b1, '1, 0, "R8 clear last");
    idle(8'h40, "R8 irq low after clear");
    idle(8'h40, "R8 settled");

    // Random traffic
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d, e;
      logic        we;
      case ($urandom_range(0, 4))
        0: a = 8'h40;
        1: a = 8'h44;
        2: a = 8'h48;
        3: a = 8'h40;
        default: a = 8'($urandom_range(0, 255));
      endcase
      we = ($urandom_range(0, 2) == 0);
      d  = $urandom();
      if ($urandom_range(0, 1) == 0) d = d & $urandom();
      e  = ($urandom_range(0, 3) == 0) ? (1 << $urandom_range(0, 31)) : 32'h0;
      step(a, we, d, e, "R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule